// File: doc/BRIEF.md
# Hardware Store Request Arbiter

This block sits behind a bidirectional, open-drain store-request/busy pin of a battery-free nonvolatile SRAM model. An external agent pulls the pin low to ask for the SRAM contents to be saved. The block synchronizes that level and then opens a grace window of a fixed length. During the window, reads carry on and a write already under way may finish, but no new write is granted. When the window closes, the block starts the store engine only if the array has been written since the last store or recall. While any store runs, the block pulls the pin low itself, so that it acts as a busy flag. After a store, or after a skipped one, SRAM access stays off until the pin is seen high again.

The block also handles the supply. A digital comparator input reports whether the supply is above the switch threshold. While it is low, a recall is held pending and all access is off. When the supply recovers, a timed recall phase runs before access resumes. A recall is also pending out of reset, so the first thing a powered part does is a recall. A one-cycle software store request starts a store at once, without a dirty check, and uses the same busy signalling. The store engine is reached through a start pulse and a done strobe. The pin appears as a drive-enable output plus a sampled input level.

Top module: `hw_store_arbiter`

## Requirements
- R1: While reset is asserted, `acc_en`, `wr_allow`, `pin_oe`, `store_go` and `recall_active` are all 0. A recall is pending after reset, so once reset is released with `supply_ok` high, `recall_active` is 1 for exactly `T_RECALL` cycles.
- R2: `pin_in` passes through a two-flop synchronizer. After the pin falls, access stays on (`acc_en`=1) for 2 synchronizer cycles plus a window of exactly `T_DELAY` cycles, and drops in the cycle after the window.
- R3: Inside the window `acc_en` stays 1 so that reads continue, while `wr_allow` is 0 for any write not already in progress.
- R4: A write counts as in progress if `wr_req` was high in the last cycle before the window. It keeps `wr_allow` at 1 until `wr_req` goes low. After that, `wr_allow` stays 0 until the pin has been seen high again.
- R5: When the window closes, a store is launched only if a write was accepted (`wr_req` and `wr_allow` both 1 at a clock edge) since the last store or recall ended. The launch is marked by `store_go`, which is 1 only in the first cycle of the store.
- R6: `pin_oe` is 1 from the cycle of `store_go` until the cycle after `store_done` is sampled, for both request-pin and software stores. During that time `acc_en` and `wr_allow` are 0.
- R7: After a store, or after a window that ends without one, `acc_en` and `wr_allow` stay 0 while the synchronized pin is low. Access returns on the third clock edge after the pin rises, and writes attempted while waiting are not accepted.
- R8: A completed store (`store_done`) clears the written-since flag, and so does the end of a recall. A later request with no new write runs no store.
- R9: One cycle after `supply_ok` goes low, `acc_en`, `pin_oe` and `recall_active` are 0. In the cycle after `supply_ok` returns high, `recall_active` becomes 1. It stays 1 for `T_RECALL` cycles, and then `acc_en` returns.
- R10: A one-cycle `sw_store` pulse while idle, with the pin high, gives `store_go` and `pin_oe` in the next cycle even if nothing was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Sampled level of the open-drain request/busy pin |
| pin_oe | output | 1 | 1 pulls the pin low (busy) |
| supply_ok | input | 1 | Supply comparator: 1 when above the switch threshold |
| sw_store | input | 1 | One-cycle software store request |
| wr_req | input | 1 | SRAM write request / write in progress |
| wr_allow | output | 1 | Write permission to the SRAM |
| acc_en | output | 1 | SRAM access (read) enable |
| store_go | output | 1 | One-cycle start pulse to the store engine |
| store_done | input | 1 | Store engine completion strobe |
| recall_active | output | 1 | High for the duration of a recall |

## Verification
The bench builds the block with `T_DELAY`=3 and `T_RECALL`=5. With these values, every cycle of the grace window and of the recall phase can be counted one by one. The bench sweeps the four combinations of a written or clean array and a write in flight or not at the moment of the request. Clean runs come between them, so it is visible whether a store or recall has actually cleared the written-since state. The short windows also leave room to cover the software store, a supply dip and a recall out of reset in the same run.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
  typedef enum logic [2:0] {
    ST_PWRLOW = 3'd0,
    ST_RECALL = 3'd1,
    ST_IDLE   = 3'd2,
    ST_DELAY  = 3'd3,
    ST_STORE  = 3'd4,
    ST_WAITHI = 3'd5
  } hsa_state_e;
endpackage

// File: rtl/hsa_sync.sv
module hsa_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hsa_timer.sv
module hsa_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);
  logic [CW-1:0] cnt, cnt_nxt;
  logic          cnt_en;

  assign zero   = (cnt == '0);
  assign cnt_en = load | !zero;

  always_comb begin
    cnt_nxt = cnt;
    if (load)      cnt_nxt = val;
    else if (!zero) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/hsa_dirty.sv
module hsa_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic dirty
);
  logic dirty_nxt;

  always_comb begin
    dirty_nxt = dirty;
    if (clr)      dirty_nxt = 1'b0;
    else if (set) dirty_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty <= 1'b0;
    else        dirty <= dirty_nxt;
  end
endmodule

// File: rtl/hw_store_arbiter.sv
module hw_store_arbiter
  import hsa_pkg::*;
#(
  parameter int T_DELAY  = 16,
  parameter int T_RECALL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_oe,
  input  logic supply_ok,
  input  logic sw_store,
  input  logic wr_req,
  output logic wr_allow,
  output logic acc_en,
  output logic store_go,
  input  logic store_done,
  output logic recall_active
);
  localparam int TMAX = (T_DELAY > T_RECALL) ? T_DELAY : T_RECALL;
  localparam int CW   = $clog2(TMAX) + 1;

  logic          arst_n;
  logic          pin_hi_s, req_s;
  hsa_state_e    st, st_nxt;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          dirty, dirty_clr, wr_acc, dirty_eff;
  logic          wr_hold, wr_hold_nxt, go_nxt;

  hsa_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(arst_n));

  hsa_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(arst_n), .d(pin_in), .q(pin_hi_s));

  assign req_s = !pin_hi_s;

  hsa_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(arst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero));

  assign wr_acc = wr_req & wr_allow;

  hsa_dirty u_dirty (
    .clk(clk), .rst_n(arst_n), .set(wr_acc), .clr(dirty_clr), .dirty(dirty));

  assign dirty_eff = dirty | wr_acc;

  // next-state logic
  always_comb begin
    st_nxt    = st;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    dirty_clr = 1'b0;
    if (!supply_ok) begin
      st_nxt = ST_PWRLOW;
    end else begin
      unique case (st)
        ST_PWRLOW: begin
          st_nxt   = ST_RECALL;
          tmr_load = 1'b1;
          tmr_val  = CW'(T_RECALL - 1);
        end
        ST_RECALL: if (tmr_zero) begin
          st_nxt    = ST_IDLE;
          dirty_clr = 1'b1;
        end
        ST_IDLE: begin
          if (req_s) begin
            st_nxt   = ST_DELAY;
            tmr_load = 1'b1;
            tmr_val  = CW'(T_DELAY - 1);
          end else if (sw_store) begin
            st_nxt = ST_STORE;
          end
        end
        ST_DELAY: if (tmr_zero) st_nxt = dirty_eff ? ST_STORE : ST_WAITHI;
        ST_STORE: if (store_done) begin
          st_nxt    = ST_WAITHI;
          dirty_clr = 1'b1;
        end
        ST_WAITHI: if (!req_s) st_nxt = ST_IDLE;
        default:   st_nxt = ST_PWRLOW;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_IDLE:  wr_hold_nxt = wr_req;
      ST_DELAY: wr_hold_nxt = wr_hold & wr_req;
      default:  wr_hold_nxt = 1'b0;
    endcase
  end

  assign go_nxt = (st_nxt == ST_STORE) && (st != ST_STORE);

  // state registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st       <= ST_PWRLOW;
      wr_hold  <= 1'b0;
      store_go <= 1'b0;
    end else begin
      st       <= st_nxt;
      wr_hold  <= wr_hold_nxt;
      store_go <= go_nxt;
    end
  end

  assign acc_en        = (st == ST_IDLE) || (st == ST_DELAY);
  assign wr_allow      = (st == ST_IDLE) || ((st == ST_DELAY) && wr_hold);
  assign pin_oe        = (st == ST_STORE);
  assign recall_active = (st == ST_RECALL);

  // R2
  window_end_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_DELAY && tmr_zero && supply_ok) |=> !acc_en);

  // R4
  late_write_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_DELAY && $past(st) == ST_DELAY && !$past(wr_req)) |-> !wr_allow);

  // R5
  go_busy_chk: assert property (@(posedge clk) disable iff (!arst_n)
    store_go |-> pin_oe);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_STORE && !store_done && supply_ok) |=> pin_oe);

  // R7
  wait_pin_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_WAITHI && !pin_hi_s) |=> !acc_en);

  // R8
  dirty_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_STORE && store_done && supply_ok) |=> !dirty);

  // R9
  recall_run_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_RECALL && !tmr_zero && supply_ok) |=> recall_active);
endmodule

// File: tb/hw_store_arbiter_test.sv
module hw_store_arbiter_test;
  localparam int TD = 3;
  localparam int TR = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pin_in, pin_oe, supply_ok, sw_store, wr_req;
  logic wr_allow, acc_en, store_go, store_done, recall_active;
  logic ext_low;

  assign pin_in = !(ext_low || pin_oe);

  hw_store_arbiter #(.T_DELAY(TD), .T_RECALL(TR)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_oe(pin_oe),
    .supply_ok(supply_ok), .sw_store(sw_store), .wr_req(wr_req),
    .wr_allow(wr_allow), .acc_en(acc_en), .store_go(store_go),
    .store_done(store_done), .recall_active(recall_active));

  int total = 0;
  int bad   = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_recall(input string req, input int lead);
    int n = 0;
    int len = 0;
    do begin tick(); n++; end while (!recall_active && n < 50);
    if (lead > 0) chk({req, " recall start"}, n, lead);
    while (recall_active && len < 100) begin len++; tick(); end
    chk({req, " recall length"}, len, TR);
    chk({req, " access after recall"}, acc_en, 1);
  endtask

  task automatic do_write();
    wr_req = 1'b1;
    tick();
    wr_req = 1'b0;
  endtask

  task automatic wait_release(input string req);
    int n = 0;
    ext_low = 1'b0;
    tick();
    while (!acc_en && n < 20) begin n++; tick(); end
    chk({req, " cycles blocked after pin rise"}, n, 2);
  endtask

  task automatic hw_case(input bit pre, input bit infl);
    bit exp_store = pre | infl;
    if (pre) do_write();
    if (infl) wr_req = 1'b1;
    ext_low = 1'b1;
    tick(); chk("R2 sync stage 1 acc_en", acc_en, 1);
    tick(); chk("R2 sync stage 2 acc_en", acc_en, 1);
    tick();
    chk("R3 window reads on", acc_en, 1);
    chk("R4 in-flight write grant", wr_allow, int'(infl));
    if (infl) wr_req = 1'b0;
    tick();
    chk("R4 grant dropped after write ends", wr_allow, 0);
    if (infl) wr_req = 1'b1;
    for (int i = 2; i < TD; i++) begin
      tick();
      chk("R3 window reads on", acc_en, 1);
      chk("R3 window new write blocked", wr_allow, 0);
    end
    tick();
    wr_req = 1'b0;
    chk("R2 access off after window", acc_en, 0);
    chk("R5 store launch", store_go, int'(exp_store));
    chk("R6 busy drive at launch", pin_oe, int'(exp_store));
    if (exp_store) begin
      wr_req = 1'b1;
      for (int i = 0; i < 3; i++) begin
        tick();
        chk("R6 busy during store", pin_oe, 1);
        chk("R5 single start pulse", store_go, 0);
        chk("R6 no write during store", wr_allow, 0);
      end
      wr_req = 1'b0;
      store_done = 1'b1;
      tick();
      store_done = 1'b0;
      chk("R6 busy released after done", pin_oe, 0);
    end else begin
      tick();
      chk("R5 no store when clean", pin_oe, 0);
    end
    wr_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R7 access held while pin low", acc_en, 0);
      chk("R7 write held while pin low", wr_allow, 0);
    end
    wr_req = 1'b0;
    wait_release("R7");
  endtask

  initial begin
    rst_n = 1'b0; ext_low = 1'b0; supply_ok = 1'b1;
    sw_store = 1'b0; wr_req = 1'b0; store_done = 1'b0;
    repeat (3) tick();
    chk("R1 reset acc_en", acc_en, 0);
    chk("R1 reset wr_allow", wr_allow, 0);
    chk("R1 reset pin_oe", pin_oe, 0);
    chk("R1 reset store_go", store_go, 0);
    chk("R1 reset recall_active", recall_active, 0);
    rst_n = 1'b1;
    wait_recall("R1", 0);

    // sweep: written/clean x write in flight, clean runs in between (R8)
    hw_case(1'b0, 1'b0);
    hw_case(1'b1, 1'b0);
    hw_case(1'b0, 1'b0);
    hw_case(1'b0, 1'b1);
    hw_case(1'b0, 1'b0);
    hw_case(1'b1, 1'b1);
    hw_case(1'b0, 1'b0);

    // R10 software store on a clean array
    sw_store = 1'b1;
    tick();
    sw_store = 1'b0;
    chk("R10 software store start", store_go, 1);
    chk("R10 software store busy", pin_oe, 1);
    for (int i = 0; i < 2; i++) begin
      tick();
      chk("R6 busy during software store", pin_oe, 1);
    end
    store_done = 1'b1;
    tick();
    store_done = 1'b0;
    chk("R6 software store release", pin_oe, 0);
    chk("R7 access off after software store", acc_en, 0);
    begin
      int n = 0;
      tick();
      while (!acc_en && n < 20) begin n++; tick(); end
      chk("R7 software store resume", n, 2);
    end

    // R9 supply dip with a write pending, then recall clears it (R8)
    do_write();
    supply_ok = 1'b0;
    wr_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R9 low supply access off", acc_en, 0);
      chk("R9 low supply no recall yet", recall_active, 0);
      chk("R9 low supply no busy", pin_oe, 0);
    end
    wr_req = 1'b0;
    supply_ok = 1'b1;
    wait_recall("R9", 1);
    hw_case(1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule